// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

This block derives a card clock from a fast base clock. The divisor is one byte made of two nibbles. The upper nibble gives the length of the high phase and the lower nibble gives the length of the low phase, each counted in base-clock cycles minus one. The output period is therefore the sum of the two phase lengths, and uneven ratios can be built by making one phase a cycle longer than the other. With a 208 MHz base, the ratios 4 through 11 give the usual card rates, from 52 MHz down to about 18.9 MHz. The reset divisor splits 11 cycles into 6 high and 5 low.

Software loads a new divisor through a single-cycle write strobe. The value is held pending and takes effect only when the next high phase starts, so the output never shows a shortened pulse. A one-cycle status pulse marks the first cycle of the high phase that uses the new value. A low-power select input swaps the divided output for a slow, always-on reference clock. The divider keeps counting underneath, so the output is back in phase with the divider as soon as the select drops.

Top module: `splitdiv_top`

## Requirements
- R1: While reset is asserted, with the low-power select low, the output clock and the update status are both 0, and the divisor returns to 0x54.
- R2: The first high phase begins on the first base-clock edge after reset is released.
- R3: Each high phase lasts (divisor bits 7..4) + 1 base-clock cycles.
- R4: Each low phase lasts (divisor bits 3..0) + 1 base-clock cycles, and it follows the high phase directly.
- R5: The corner divisors work: 0x00 divides by 2 (one cycle high, one low) and 0xFF divides by 32 (16 high, 16 low).
- R6: A divisor written during a period does not change that period. The new value governs the phases starting with the next high phase. A write on the same edge that starts a high phase stays pending until the following one.
- R7: The update status is 1 for exactly the first cycle of the high phase that first uses a newly written divisor, and it is 0 at all other times.
- R8: When several writes occur before a period boundary, only the last one written takes effect.
- R9: While the low-power select is 1, the output clock equals the reference input. The divider keeps running, so after the select returns to 0 the output shows the divider phase that would have been present without the bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast base clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| wr_en_i | input | 1 | Divisor write strobe, one cycle per write |
| wr_data_i | input | 8 | New divisor: high-phase nibble in 7..4, low-phase nibble in 3..0 |
| lowpwr_i | input | 1 | Selects the always-on reference in place of the divided clock |
| ref_clk_i | input | 1 | Slow always-on reference clock |
| clk_o | output | 1 | Divided clock, or the reference while in low power |
| applied_o | output | 1 | One-cycle pulse when a pending divisor takes effect |

## Verification
On every cycle, the embedded assertions check four things. The phase counter never exceeds the nibble of the active divisor for the current phase. Each phase ends exactly when its count runs out. The active divisor stays stable between period boundaries. The status pulse falls only inside a high phase. Other behaviours need the bench's scenarios and its cycle-by-cycle reference model. These include the exact phase widths for each standard ratio and the two corner divisors, last-write-wins ordering, the hold of a write landing on a boundary, and the output re-emerging in the correct phase after a bypass interval.

// File: rtl/splitdiv_pkg.sv
package splitdiv_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;

endpackage

// File: rtl/splitdiv_update.sv
module splitdiv_update #(
   parameter int NIB_W       = 4,
   parameter int DEFAULT_DIV = 'h54
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [2*NIB_W-1:0] wr_data_i,
   input  logic               start_i,
   output logic [2*NIB_W-1:0] cur_div_o,
   output logic [2*NIB_W-1:0] nxt_div_o,
   output logic               applied_o
);

   localparam int DIV_W = 2 * NIB_W;
   localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(DEFAULT_DIV);

   logic [DIV_W-1:0] cur_q;
   logic [DIV_W-1:0] pend_val_q;
   logic             pend_q;
   logic             applied_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cur_q      <= RST_DIV;
         pend_val_q <= RST_DIV;
         pend_q     <= 1'b0;
         applied_q  <= 1'b0;
      end else begin
         applied_q <= start_i && pend_q;
         if (start_i && pend_q) begin
            cur_q <= pend_val_q;
         end
         if (start_i) begin
            pend_q <= wr_en_i;
         end else begin
            pend_q <= pend_q || wr_en_i;
         end
         if (wr_en_i) begin
            pend_val_q <= wr_data_i;
         end
      end
   end

   assign cur_div_o = cur_q;
   assign nxt_div_o = pend_q ? pend_val_q : cur_q;
   assign applied_o = applied_q;

   // R6
   div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(cur_q));

endmodule

// File: rtl/splitdiv_counter.sv
module splitdiv_counter
   import splitdiv_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [2*NIB_W-1:0] cur_div_i,
   input  logic [2*NIB_W-1:0] nxt_div_i,
   output logic               start_o,
   output logic               high_o
);

   localparam int DIV_W = 2 * NIB_W;

   phase_e             st_q;
   logic [NIB_W-1:0]   cnt_q;
   logic [NIB_W-1:0]   cur_hi;
   logic [NIB_W-1:0]   cur_lo;
   logic [NIB_W-1:0]   nxt_hi;

   assign cur_hi = cur_div_i[DIV_W-1:NIB_W];
   assign cur_lo = cur_div_i[NIB_W-1:0];
   assign nxt_hi = nxt_div_i[DIV_W-1:NIB_W];

   assign start_o = (st_q == PH_IDLE) || ((st_q == PH_LOW) && (cnt_q == '0));
   assign high_o  = (st_q == PH_HIGH);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            PH_IDLE: begin
               st_q  <= PH_HIGH;
               cnt_q <= nxt_hi;
            end
            PH_HIGH: begin
               if (cnt_q == '0) begin
                  st_q  <= PH_LOW;
                  cnt_q <= cur_lo;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_LOW: begin
               if (cnt_q == '0) begin
                  st_q  <= PH_HIGH;
                  cnt_q <= nxt_hi;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               st_q  <= PH_IDLE;
               cnt_q <= '0;
            end
         endcase
      end
   end

   // R2
   first_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PH_IDLE) |=> (st_q == PH_HIGH));

   // R3
   high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PH_HIGH) |-> (cnt_q <= cur_hi));

   // R4
   low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PH_LOW) |-> (cnt_q <= cur_lo));

   // R4
   high_to_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q == PH_HIGH) && (cnt_q == '0)) |=> (st_q == PH_LOW));

endmodule

// File: rtl/splitdiv_outmux.sv
module splitdiv_outmux #(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic div_i,
   input  logic ref_i,
   input  logic lowpwr_i,
   output logic clk_o
);

   generate
      if (BYPASS_EN) begin : g_bypass
         assign clk_o = lowpwr_i ? ref_i : div_i;
      end else begin : g_direct
         logic unused_sel;
         assign unused_sel = ref_i ^ lowpwr_i;
         assign clk_o = div_i;
      end
   endgenerate

endmodule

// File: rtl/splitdiv_top.sv
module splitdiv_top #(
   parameter int NIB_W       = 4,
   parameter int DEFAULT_DIV = 'h54,
   parameter bit BYPASS_EN   = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [2*NIB_W-1:0] wr_data_i,
   input  logic               lowpwr_i,
   input  logic               ref_clk_i,
   output logic               clk_o,
   output logic               applied_o
);

   localparam int DIV_W = 2 * NIB_W;

   generate
      if (NIB_W < 1 || NIB_W > 8) begin : g_bad_nib
         $error("splitdiv_top: NIB_W must be 1..8");
      end
      if (DEFAULT_DIV < 0 || DEFAULT_DIV >= (1 << DIV_W)) begin : g_bad_def
         $error("splitdiv_top: DEFAULT_DIV does not fit the divisor");
      end
   endgenerate

   logic [DIV_W-1:0] cur_div;
   logic [DIV_W-1:0] nxt_div;
   logic             start;
   logic             div_high;

   splitdiv_update #(
      .NIB_W       (NIB_W),
      .DEFAULT_DIV (DEFAULT_DIV)
   ) update_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .start_i   (start),
      .cur_div_o (cur_div),
      .nxt_div_o (nxt_div),
      .applied_o (applied_o)
   );

   splitdiv_counter #(
      .NIB_W (NIB_W)
   ) counter_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cur_div_i (cur_div),
      .nxt_div_i (nxt_div),
      .start_o   (start),
      .high_o    (div_high)
   );

   splitdiv_outmux #(
      .BYPASS_EN (BYPASS_EN)
   ) outmux_i (
      .div_i    (div_high),
      .ref_i    (ref_clk_i),
      .lowpwr_i (lowpwr_i),
      .clk_o    (clk_o)
   );

   // R7
   applied_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      applied_o |-> div_high);

endmodule

// File: tb/splitdiv_top_tb_top.sv
module splitdiv_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       lowpwr = 1'b0;
   logic       refc = 1'b0;
   logic       clk_out;
   logic       applied;

   int checks = 0;
   int errors = 0;
   int cycle = 0;
   string req = "R1";

   // behavioural reference model
   bit   m_started = 0;
   bit   m_out = 0;
   bit   m_applied = 0;
   int   m_left = 0;
   int   m_cur = 'h54;
   int   m_pv = 'h54;
   bit   m_pend = 0;

   always #2 clk = ~clk;

   splitdiv_top dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .lowpwr_i  (lowpwr),
      .ref_clk_i (refc),
      .clk_o     (clk_out),
      .applied_o (applied)
   );

   always @(posedge clk) begin
      bit st;
      cycle++;
      if (!rst_n) begin
         m_started = 0; m_out = 0; m_applied = 0; m_left = 0;
         m_cur = 'h54; m_pv = 'h54; m_pend = 0;
      end else begin
         st = !m_started || (m_out == 0 && m_left == 1);
         m_applied = 0;
         if (st) begin
            if (m_pend) begin
               m_cur = m_pv;
               m_applied = 1;
            end
            m_started = 1;
            m_out = 1;
            m_left = (m_cur >> 4) + 1;
         end else if (m_out == 1 && m_left == 1) begin
            m_out = 0;
            m_left = (m_cur & 15) + 1;
         end else begin
            m_left--;
         end
         if (st) m_pend = wr_en;
         else m_pend = m_pend || wr_en;
         if (wr_en) m_pv = wr_data;
      end
   end

   // compare once per cycle, 1 ns after the edge
   always @(posedge clk) begin
      bit exp_clk;
      #1;
      exp_clk = lowpwr ? refc : m_out;
      checks++;
      if (clk_out !== exp_clk || applied !== m_applied) begin
         errors++;
         $display("FAIL %s cycle %0d: clk_o=%b applied_o=%b expected clk_o=%b applied_o=%b",
                  req, cycle, clk_out, applied, exp_clk, m_applied);
      end
   end

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if ((cycle % 7) == 0) refc = ~refc;
      end
   endtask

   task automatic write_div(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // measure one full period starting at a rising edge of clk_out
   task automatic measure(input string tag, input int exp_hi, input int exp_lo);
      int hi = 0;
      int lo = 0;
      int guard = 0;
      @(negedge clk);
      while (!(clk_out == 1'b0) && guard < 100) begin @(negedge clk); guard++; end
      while (!(clk_out == 1'b1) && guard < 100) begin @(negedge clk); guard++; end
      while (clk_out == 1'b1 && guard < 100) begin hi++; @(negedge clk); guard++; end
      while (clk_out == 1'b0 && guard < 100) begin lo++; @(negedge clk); guard++; end
      checks++;
      if (hi != exp_hi || lo != exp_lo) begin
         errors++;
         $display("FAIL %s phase widths: high=%0d low=%0d expected high=%0d low=%0d",
                  tag, hi, lo, exp_hi, exp_lo);
      end
   endtask

   initial begin : watchdog
      #400000;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycle);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int rates [8] = '{'h11, 'h21, 'h22, 'h32, 'h33, 'h43, 'h44, 'h54};
      // R1: reset state
      req = "R1";
      run(4);
      // R2: first high after release
      req = "R2";
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (clk_out !== 1'b1) begin
         errors++;
         $display("FAIL R2 first cycle after reset: clk_o=%b expected 1", clk_out);
      end
      // R3 R4: default divide-by-11
      req = "R3";
      measure("R3", 6, 5);
      req = "R4";
      run(15);
      // R6: mid-period write, and R5 divide by 2
      req = "R6";
      run(3);
      write_div(8'h00);
      run(14);
      req = "R5";
      measure("R5", 1, 1);
      write_div(8'hFF);
      run(40);
      measure("R5", 16, 16);
      // R8: last write wins
      req = "R8";
      write_div(8'h21);
      write_div(8'h32);
      run(40);
      measure("R8", 4, 3);
      // R7: pulse only on application; back-to-back writes on every cycle
      req = "R7";
      write_div(8'h10);
      run(1);
      write_div(8'h01);
      run(20);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         wr_en = 1'b1;
         wr_data = (k % 2) ? 8'h00 : 8'h10;
      end
      @(negedge clk);
      wr_en = 1'b0;
      run(20);
      // standard ratios 4..11
      req = "R4";
      for (int k = 0; k < 8; k++) begin
         write_div(rates[k][7:0]);
         run(25);
         measure("R3", (rates[k] >> 4) + 1, (rates[k] & 15) + 1);
      end
      // R9: low-power bypass
      req = "R9";
      write_div(8'h32);
      run(30);
      @(negedge clk);
      lowpwr = 1'b1;
      run(45);
      write_div(8'h11);
      run(20);
      @(negedge clk);
      lowpwr = 1'b0;
      run(30);
      // R1: reset mid-run
      req = "R1";
      @(negedge clk);
      rst_n = 1'b0;
      run(3);
      req = "R2";
      @(negedge clk);
      rst_n = 1'b1;
      run(30);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule